// File: doc/BRIEF.md
# NAND One-Bit ECC Parity Accumulator

This block builds a 24-bit parity code, able to locate any single flipped bit, over each 512-byte block of data that passes through a NAND data path. It keeps a separate code context for each of four external chip selects. Every byte presented on the data path counts toward the context of the chip select that carries it. A byte is only taken if that select is in NAND mode and its accumulation has been started.

Software uses a small word-addressed register port. A control register holds one NAND-mode bit for each select. It also takes a write-one start bit for each select, which arms that select's byte counter. Each select has its own result register. Reading that register returns the two 12-bit code halves and clears the code, so the next block begins from zero. Once a context has taken a full block of bytes it freezes and ignores further bytes until it is restarted.

Top module: `nand_ecc1_acc`

## Requirements
- R1: After reset every code is zero, the control register reads zero and no context is started, so bytes on any select leave the codes unchanged until a start is written.
- R2: Control register is word address 0. Bits [3:0] are the NAND-mode bits for selects 0..3 and read back as written. Bits [11:8] are start bits and read as zero. All other bits read as zero.
- R3: Writing the control register with bit (8+n) set starts select n: its byte counter returns to zero and accumulation is enabled. A control write with bit (8+n) clear leaves select n's counter and code untouched.
- R4: A byte with nd_vld high updates only the context of the select on nd_cs, and only if that select's mode bit is set and it has been started.
- R5: The bit address of data bit j of the k-th byte of a block (k counted from 0 since the start) is k*8+j, 12 bits wide. For each 1 bit, the upper half XORs in that address and the lower half XORs in its bitwise complement.
- R6: After 512 bytes a context takes no more bytes, and its code is unchanged until it is restarted.
- R7: The result register of select n is at word address 4+n. It returns the upper half in bits [27:16] and the lower half in bits [11:0]. Bits [31:28] and [15:12] read as zero.
- R8: Reading a result register clears that select's code. A byte taken in the same cycle as the read becomes the whole content of the new code.
- R9: A read returns its data on reg_rdata in the cycle after reg_rd. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| nd_vld | input | 1 | A data byte is on the NAND path this cycle |
| nd_cs | input | 2 | Chip select carrying the byte |
| nd_byte | input | 8 | Data byte |

## Verification
Every internal error in this block shows up in a result register. It appears at the next read of the affected select. That read comes one block of 512 bytes after the fault at most, or sooner in the directed tests. A wrong byte counter puts a wrong address into every later byte's contribution. A missed freeze lets the extra bytes alter the code. Leakage between contexts spoils the code of the select that should have stayed quiet. A missed clear leaves the previous block's code XORed into the next one.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned START_LSB  = 8;
   localparam int unsigned HI_LSB     = 16;
   localparam int unsigned CTRL_ADDR  = 0;
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity #(
   parameter  int DATA_W = 8,
   parameter  int IDX_W  = 9,
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int HALF_W = IDX_W + BIT_W
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [HALF_W-1:0] hi_o,
   output logic [HALF_W-1:0] lo_o
);
   initial begin
      assert (DATA_W >= 2 && (1 << BIT_W) == DATA_W)
         else $fatal(1, "DATA_W must be a power of two of at least 2");
   end

   logic odd_ones;

   always_comb begin
      hi_o     = '0;
      odd_ones = ^data_i;
      for (int j = 0; j < DATA_W; j++) begin
         if (data_i[j]) hi_o = hi_o ^ {idx_i, BIT_W'(j)};
      end
      lo_o = hi_o ^ {HALF_W{odd_ones}};
   end
endmodule

// File: rtl/ecc_ctx.sv
module ecc_ctx #(
   parameter  int DATA_W    = 8,
   parameter  int BLK_BYTES = 512,
   localparam int IDX_W     = $clog2(BLK_BYTES),
   localparam int CNT_W     = IDX_W + 1,
   localparam int HALF_W    = IDX_W + $clog2(DATA_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  mode_i,
   input  logic                  vld_i,
   input  logic [DATA_W-1:0]     data_i,
   input  logic                  clr_i,
   output logic [2*HALF_W-1:0]   code_o
);
   initial begin
      assert ((1 << IDX_W) == BLK_BYTES)
         else $fatal(1, "BLK_BYTES must be a power of two");
   end

   logic              run_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HALF_W-1:0] hi_q, lo_q, hi_c, lo_c;
   logic              take;

   assign take = run_q && mode_i && vld_i && !start_i &&
                 (cnt_q < CNT_W'(BLK_BYTES));

   ecc_byte_parity #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_par (
      .data_i (data_i),
      .idx_i  (cnt_q[IDX_W-1:0]),
      .hi_o   (hi_c),
      .lo_o   (lo_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (take) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= (clr_i ? '0 : hi_q) ^ (take ? hi_c : '0);
         lo_q <= (clr_i ? '0 : lo_q) ^ (take ? lo_c : '0);
      end
   end

   assign code_o = {hi_q, lo_q};

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BLK_BYTES));
   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(BLK_BYTES) && !start_i && !clr_i) |=> $stable(code_o));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !vld_i) |=> (code_o == '0));
   p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && !clr_i) |=> $stable(code_o));
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !clr_i) |=> $stable(code_o));
   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == '0));
   p_no_disturb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !vld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
   import nand_ecc_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int ADDR_W   = 4,
   parameter int RES_BASE = 4,
   parameter int HALF_W   = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_i,
   input  logic [ADDR_W-1:0]                  waddr_i,
   input  logic [REG_W-1:0]                   wdata_i,
   input  logic                               rd_i,
   input  logic [ADDR_W-1:0]                  raddr_i,
   output logic [REG_W-1:0]                   rdata_o,
   input  logic [NUM_CS-1:0][2*HALF_W-1:0]    codes_i,
   output logic [NUM_CS-1:0]                  mode_o,
   output logic [NUM_CS-1:0]                  start_o,
   output logic [NUM_CS-1:0]                  clr_o
);
   localparam logic [REG_W-1:0] HALF_ONES = REG_W'((64'd1 << HALF_W) - 64'd1);
   localparam logic [REG_W-1:0] RES_MASK  = HALF_ONES | (HALF_ONES << HI_LSB);

   initial begin
      assert (HALF_W <= int'(HI_LSB) && int'(HI_LSB) + HALF_W <= int'(REG_W))
         else $fatal(1, "code halves do not fit the result word");
      assert (RES_BASE > int'(CTRL_ADDR) && RES_BASE + NUM_CS <= (1 << ADDR_W))
         else $fatal(1, "result registers outside the address space");
      assert (NUM_CS <= int'(START_LSB) && int'(START_LSB) + NUM_CS <= int'(REG_W))
         else $fatal(1, "control fields overlap");
   end

   logic [NUM_CS-1:0] mode_q;
   logic [REG_W-1:0]  rd_nx, rdata_q;
   logic              ctrl_wr;
   logic              unused_wdata;

   assign ctrl_wr      = wr_i && (waddr_i == ADDR_W'(CTRL_ADDR));
   assign unused_wdata = ^wdata_i;

   generate
      for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
         assign start_o[n] = ctrl_wr && wdata_i[START_LSB + n];
         assign clr_o[n]   = rd_i && (raddr_i == ADDR_W'(RES_BASE + n));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (ctrl_wr) mode_q <= wdata_i[NUM_CS-1:0];
   end

   always_comb begin
      rd_nx = '0;
      if (raddr_i == ADDR_W'(CTRL_ADDR)) rd_nx[NUM_CS-1:0] = mode_q;
      for (int n = 0; n < NUM_CS; n++) begin
         if (raddr_i == ADDR_W'(RES_BASE + n)) begin
            rd_nx[HI_LSB +: HALF_W] = codes_i[n][2*HALF_W-1:HALF_W];
            rd_nx[HALF_W-1:0]       = codes_i[n][HALF_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_nx;
   end

   assign rdata_o = rdata_q;
   assign mode_o  = mode_q;

   p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o & ~RES_MASK) == '0);
   p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && raddr_i == ADDR_W'(CTRL_ADDR)) |=> (rdata_o >> NUM_CS) == '0);
   p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/nand_ecc1_acc.sv
module nand_ecc1_acc
   import nand_ecc_pkg::*;
#(
   parameter  int NUM_CS    = 4,
   parameter  int DATA_W    = 8,
   parameter  int BLK_BYTES = 512,
   parameter  int ADDR_W    = 4,
   parameter  int RES_BASE  = 4,
   localparam int CS_W      = $clog2(NUM_CS),
   localparam int HALF_W    = $clog2(BLK_BYTES) + $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              nd_vld,
   input  logic [CS_W-1:0]   nd_cs,
   input  logic [DATA_W-1:0] nd_byte
);
   initial begin
      assert (NUM_CS >= 2 && (1 << CS_W) == NUM_CS)
         else $fatal(1, "NUM_CS must be a power of two of at least 2");
   end

   logic [NUM_CS-1:0][2*HALF_W-1:0] codes;
   logic [NUM_CS-1:0]               mode, start, clr;

   ecc_regs #(
      .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .RES_BASE(RES_BASE), .HALF_W(HALF_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
      .rd_i(reg_rd), .raddr_i(reg_raddr), .rdata_o(reg_rdata),
      .codes_i(codes), .mode_o(mode), .start_o(start), .clr_o(clr)
   );

   generate
      for (genvar n = 0; n < NUM_CS; n++) begin : g_ctx
         logic sel_vld;
         assign sel_vld = nd_vld && (nd_cs == CS_W'(n));
         ecc_ctx #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)) u_ctx (
            .clk(clk), .rst_n(rst_n),
            .start_i(start[n]), .mode_i(mode[n]), .vld_i(sel_vld),
            .data_i(nd_byte), .clr_i(clr[n]), .code_o(codes[n])
         );
      end
   endgenerate
endmodule

// File: tb/tb_nand_ecc1_acc.sv
`timescale 1ns/1ps
module tb_nand_ecc1_acc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, nd_vld = 1'b0;
   logic [3:0]  reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [1:0]  nd_cs = '0;
   logic [7:0]  nd_byte = '0;
   int          n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   nand_ecc1_acc dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata), .nd_vld(nd_vld), .nd_cs(nd_cs), .nd_byte(nd_byte)
   );

   typedef struct packed { logic [1:0] cs; logic [2:0] kind; logic [7:0] seed; } vec_t;
   localparam vec_t VEC [8] = '{
      '{2'd0, 3'd0, 8'd0},  '{2'd1, 3'd1, 8'd0},  '{2'd2, 3'd2, 8'h5A},
      '{2'd3, 3'd3, 8'd37}, '{2'd0, 3'd4, 8'd200}, '{2'd1, 3'd5, 8'h81},
      '{2'd2, 3'd4, 8'd0},  '{2'd3, 3'd3, 8'd255}};

   function automatic logic [7:0] pat(input logic [2:0] kind, input logic [7:0] seed, input int i);
      case (kind)
         3'd0:    return 8'hFF;
         3'd1:    return 8'h00;
         3'd2:    return 8'(i) ^ seed;
         3'd3:    return 8'(i * int'(seed) + (i >> 3));
         3'd4:    return (i == int'(seed) * 2) ? 8'h10 : 8'h00;
         default: return (8'h01 << (i % 8)) ^ seed;
      endcase
   endfunction

   // model of R5 and R7 over bytes first..first+num-1 (block indices)
   function automatic logic [31:0] model(input logic [2:0] kind, input logic [7:0] seed,
                                         input int first, input int num);
      logic [11:0] hi = '0, lo = '0;
      for (int i = first; i < first + num; i++) begin
         logic [7:0] b = pat(kind, seed, i);
         for (int j = 0; j < 8; j++)
            if (b[j]) begin
               hi ^= 12'(i * 8 + j);
               lo ^= ~12'(i * 8 + j);
            end
      end
      return {4'h0, hi, 4'h0, lo};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_raddr = a;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic send(input logic [1:0] cs, input logic [7:0] b);
      @(negedge clk); nd_vld = 1'b1; nd_cs = cs; nd_byte = b;
      @(negedge clk); nd_vld = 1'b0;
   endtask

   task automatic start_cs(input logic [3:0] mode, input logic [3:0] starts);
      wr_reg(4'd0, {20'd0, starts, 4'd0, mode});
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R2: reset state
      rd_reg(4'd0, r); check("R1 ctrl after reset", r, 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd_reg(4'(4 + c), r); check("R1 code after reset", r, 32'h0);
      end
      // R1: mode on but never started, bytes ignored
      start_cs(4'hF, 4'h0);
      for (int i = 0; i < 8; i++) send(2'd0, 8'hA5);
      rd_reg(4'd4, r); check("R1 unstarted select ignores bytes", r, 32'h0);

      // R5, R4, R7: table of blocks
      foreach (VEC[v]) begin
         start_cs(4'hF, 4'(1 << VEC[v].cs));
         for (int i = 0; i < 512; i++) send(VEC[v].cs, pat(VEC[v].kind, VEC[v].seed, i));
         rd_reg(4'(4 + VEC[v].cs), r);
         check("R5 block code", r, model(VEC[v].kind, VEC[v].seed, 0, 512));
      end

      // R2: start bits read zero, mode bits read back
      wr_reg(4'd0, 32'hF0F0_0F05);
      rd_reg(4'd0, r); check("R2 ctrl readback", r, 32'h0000_0005);
      // R9: unmapped address reads zero
      rd_reg(4'd2, r); check("R9 unmapped read", r, 32'h0);
      rd_reg(4'd9, r); check("R9 unmapped read high", r, 32'h0);

      // R6: bytes beyond 512 ignored
      start_cs(4'hF, 4'b0100);
      for (int i = 0; i < 512; i++) send(2'd2, pat(3'd3, 8'd11, i));
      for (int i = 0; i < 20; i++) send(2'd2, 8'hFF);
      rd_reg(4'd6, r); check("R6 freeze after full block", r, model(3'd3, 8'd11, 0, 512));

      // R4: mode bit clear gates bytes
      start_cs(4'hE, 4'b0001);
      for (int i = 0; i < 10; i++) send(2'd0, 8'h3C);
      rd_reg(4'd4, r); check("R4 mode off ignores bytes", r, 32'h0);

      // R4: interleaved selects stay separate
      start_cs(4'hF, 4'b1010);
      for (int i = 0; i < 64; i++) begin
         send(2'd1, pat(3'd2, 8'd3, i));
         send(2'd3, pat(3'd5, 8'd9, i));
      end
      rd_reg(4'd5, r); check("R4 isolation select 1", r, model(3'd2, 8'd3, 0, 64));
      rd_reg(4'd7, r); check("R4 isolation select 3", r, model(3'd5, 8'd9, 0, 64));
      rd_reg(4'd6, r); check("R4 untouched select 2", r, 32'h0);

      // R3: starting another select does not disturb select 0
      start_cs(4'hF, 4'b0001);
      for (int i = 0; i < 100; i++) send(2'd0, pat(3'd2, 8'd77, i));
      start_cs(4'hF, 4'b0010);
      for (int i = 100; i < 512; i++) send(2'd0, pat(3'd2, 8'd77, i));
      rd_reg(4'd4, r); check("R3 select 0 undisturbed", r, model(3'd2, 8'd77, 0, 512));
      rd_reg(4'd5, r); check("R3 select 1 started empty", r, 32'h0);

      // R8: read clears
      rd_reg(4'd4, r); check("R8 second read is zero", r, 32'h0);

      // R8: byte in the same cycle as the clearing read is kept
      start_cs(4'hF, 4'b1000);
      for (int i = 0; i < 5; i++) send(2'd3, pat(3'd2, 8'd19, i));
      @(negedge clk);
      reg_rd = 1'b1; reg_raddr = 4'd7;
      nd_vld = 1'b1; nd_cs = 2'd3; nd_byte = pat(3'd2, 8'd19, 5);
      @(negedge clk);
      reg_rd = 1'b0; nd_vld = 1'b0; r = reg_rdata;
      check("R8 read returns code before byte", r, model(3'd2, 8'd19, 0, 5));
      rd_reg(4'd7, r); check("R8 same-cycle byte kept", r, model(3'd2, 8'd19, 5, 1));

      summary();
   end
endmodule